// File: doc/BRIEF.md
# CD Data Controller Register Interface

This block is the register interface of a CD data controller. A host reaches sixteen byte-wide registers through a 4-bit register pointer and one data port. Reads and writes use different register maps. Most accesses move the pointer on to the next register, so a host can stream a run of registers without reloading the pointer.

The block holds the interface control and status bytes, the 16-bit transfer byte count, the buffer start address, the write address, the block pointer, the four header bytes, the control bytes and the decode status. A write of the matching register produces a one-cycle transfer-start, transfer-stop, acknowledge or soft-reset pulse for the transfer datapath. A header-update strobe loads the header from a binary minute/second/frame position. The last status byte reports "decode ready" only after the host has read a fixed set of registers.

Interface status flags are active low: a set bit means the event is absent. The datapath clears flags through `flag_clr`.

Top module: `cdc_regs`

## Requirements
- R1: A read (`rd_en`) at pointer 0x0 to 0xE moves the pointer to pointer+1 on that edge. A read at 0xF leaves the pointer at 0xF. `ptr_ld` loads `ptr_val` and takes precedence over any access in the same cycle.
- R2: A write (`wr_en`) moves the pointer to pointer+1, except at 0x6, 0x7, 0xE and 0xF, where the pointer stays.
- R3: The write map is: 0 sub-byte out, 1 interface control, 2/3 count low/high, 4/5 buffer address low/high (driven on `buf_addr`), 6 trigger, 7 acknowledge, 8/9 write address low/high, A/B/E control 0/1/2, C/D block pointer low/high, F reset. The read map is: 0 command input (reads 0), 1 interface status, 2/3 count, 4-7 header bytes 0-3, 8/9 block pointer, A/B write address, C-F status 0-3.
- R4: After reset the block reads as follows: interface status 0xFF; header bytes 0x00, 0x00, 0x00, 0x01; write address 0x1260 (4704); status 0 equal to 0x80; every other register 0. The pointer is 0.
- R5: Writing interface control with bit 1 = 0 zeroes the byte count, sets interface status bit 3 and pulses `xfer_stop`.
- R6: A trigger write (register 6) while interface control bit 1 = 1 clears interface status bit 3 and pulses `xfer_start`. With bit 1 = 0 the write changes nothing.
- R7: An acknowledge write (register 7) sets interface status bit 6 and pulses `xfer_ack`.
- R8: A read of status 3 returns its current value and sets interface status bit 5. If control 0 bit 7 = 1, interface control bit 5 = 1, and registers 1, 4-9 and C-E have all been read since the last reset, the same read loads status 3 with 0x80.
- R9: A write to register 0xF restores the R4 values, clears the read-tracking set, pulses `soft_rst` and keeps the pointer at 0xF.
- R10: On `hdr_upd` the header loads zeros when control 1 bit 0 = 1. Otherwise it loads the BCD minute, second and frame into bytes 0-2 and 0x01 into byte 3.
- R11: Each of `xfer_start`, `xfer_stop`, `xfer_ack` and `soft_rst` is high for exactly the one cycle after its triggering write.
- R12: `rd_data` updates on the clock edge of a read and holds its value until the next read. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_ld | input | 1 | Load the register pointer |
| ptr_val | input | 4 | Pointer value to load |
| rd_en | input | 1 | Read strobe at the current pointer |
| wr_en | input | 1 | Write strobe at the current pointer |
| wr_data | input | 8 | Write data |
| flag_clr | input | 8 | Datapath clears these interface status bits |
| hdr_upd | input | 1 | Header update strobe |
| hdr_min | input | 7 | Binary minute (0-99) |
| hdr_sec | input | 7 | Binary second (0-99) |
| hdr_frm | input | 7 | Binary frame (0-99) |
| rd_data | output | 8 | Registered read data |
| ptr | output | 4 | Current register pointer |
| buf_addr | output | 16 | Buffer start address |
| sub_out | output | 8 | Sub-byte output register |
| ctrl_word | output | 24 | Control 2, 1, 0 (MSB first) |
| xfer_start | output | 1 | Transfer start pulse |
| xfer_stop | output | 1 | Transfer stop pulse |
| xfer_ack | output | 1 | Transfer acknowledge pulse |
| soft_rst | output | 1 | Soft reset pulse |

## Verification
The pointer is run through consecutive reads and writes from several start points, so that both the advancing registers and the holding registers (6, 7, E, F) are reached. For the decode-ready rule the bench reads the tracked registers in three ways: every tracked register except one, which must keep status 3 at zero; every register with the interrupt enable clear, which must also keep it at zero; and the complete set, where the first status-3 read still returns the old value and only the second returns 0x80. The trigger is tried with the transfer enable both clear and set. The header is loaded from two different positions and with sub-header mode set, which checks the BCD conversion separately from the zero fill.

// File: rtl/cdc_regs_pkg.sv
package cdc_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 4;

  // read map
  localparam logic [PTR_W-1:0] R_CMD  = 4'h0, R_IFST = 4'h1, R_CNTL = 4'h2, R_CNTH = 4'h3;
  localparam logic [PTR_W-1:0] R_HD0  = 4'h4, R_HD1  = 4'h5, R_HD2  = 4'h6, R_HD3  = 4'h7;
  localparam logic [PTR_W-1:0] R_BPL  = 4'h8, R_BPH  = 4'h9, R_WAL  = 4'hA, R_WAH  = 4'hB;
  localparam logic [PTR_W-1:0] R_ST0  = 4'hC, R_ST1  = 4'hD, R_ST2  = 4'hE, R_ST3  = 4'hF;

  // write map
  localparam logic [PTR_W-1:0] W_SUB  = 4'h0, W_IFCT = 4'h1, W_CNTL = 4'h2, W_CNTH = 4'h3;
  localparam logic [PTR_W-1:0] W_ADL  = 4'h4, W_ADH  = 4'h5, W_TRIG = 4'h6, W_ACK  = 4'h7;
  localparam logic [PTR_W-1:0] W_WAL  = 4'h8, W_WAH  = 4'h9, W_CT0  = 4'hA, W_CT1  = 4'hB;
  localparam logic [PTR_W-1:0] W_BPL  = 4'hC, W_BPH  = 4'hD, W_CT2  = 4'hE, W_RST  = 4'hF;

  // bit positions
  localparam int IFS_XFER_N = 3;
  localparam int IFS_DEC_N  = 5;
  localparam int IFS_END_N  = 6;
  localparam int IFC_XEN    = 1;
  localparam int IFC_DECIE  = 5;
  localparam int CT0_DECEN  = 7;
  localparam int CT1_SUBHDR = 0;
endpackage

// File: rtl/cdc_ptr_unit.sv
module cdc_ptr_unit #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             rd_step,
  input  logic             wr_step,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST   = '1;
  localparam logic [PTR_W-1:0] TRIG_I = PTR_W'(6);
  localparam logic [PTR_W-1:0] ACK_I  = PTR_W'(7);

  logic wr_hold;
  assign wr_hold = (ptr == TRIG_I) || (ptr == ACK_I) || (ptr == LAST - 1'b1) || (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst)                        ptr <= '0;
    else if (ld)                    ptr <= ld_val;
    else if (wr_step && !wr_hold)   ptr <= ptr + 1'b1;
    else if (wr_step)               ptr <= ptr;
    else if (rd_step && ptr != LAST) ptr <= ptr + 1'b1;
  end

  // R1
  rd_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_step && !wr_step && !ld && ptr != LAST) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
  // R1
  rd_last_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_step && !wr_step && !ld && ptr == LAST) |=> $stable(ptr));
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_step && !ld && (ptr == TRIG_I || ptr == ACK_I || ptr == LAST - 1'b1 || ptr == LAST)) |=> $stable(ptr));
endmodule

// File: rtl/cdc_read_track.sv
module cdc_read_track #(
  parameter int          NREG      = 16,
  parameter logic [15:0] TRACK_SET = 16'h73F2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    rd_hit,
  input  logic [$clog2(NREG)-1:0] idx,
  output logic                    full
);
  logic [NREG-1:0] seen;

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    if (TRACK_SET[i]) begin : g_trk
      always_ff @(posedge clk) begin
        if (rst || clr)                          seen[i] <= 1'b0;
        else if (rd_hit && idx == i[$clog2(NREG)-1:0]) seen[i] <= 1'b1;
      end
    end else begin : g_none
      assign seen[i] = 1'b0;
    end
  end

  assign full = &(seen | ~TRACK_SET[NREG-1:0]);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(full) |-> $past(clr));
endmodule

// File: rtl/cdc_hdr_bcd.sv
module cdc_hdr_bcd #(
  parameter int VAL_W  = 7,
  parameter int NFIELD = 3
) (
  input  logic [NFIELD-1:0][VAL_W-1:0] vals,
  output logic [NFIELD-1:0][7:0]       bcd
);
  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    logic [VAL_W-1:0] tens, ones;
    assign tens   = vals[f] / VAL_W'(10);
    assign ones   = vals[f] % VAL_W'(10);
    assign bcd[f] = {tens[3:0], ones[3:0]};
  end
endmodule

// File: rtl/cdc_regs.sv
module cdc_regs
  import cdc_regs_pkg::*;
#(
  parameter int          TIME_W    = 7,
  parameter logic [15:0] WA_INIT   = 16'd4704,
  parameter logic [15:0] TRACK_SET = 16'h73F2,
  parameter logic [7:0]  ST0_INIT  = 8'h80
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ptr_ld,
  input  logic [PTR_W-1:0]    ptr_val,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [BYTE_W-1:0]   flag_clr,
  input  logic                hdr_upd,
  input  logic [TIME_W-1:0]   hdr_min,
  input  logic [TIME_W-1:0]   hdr_sec,
  input  logic [TIME_W-1:0]   hdr_frm,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [PTR_W-1:0]    ptr,
  output logic [2*BYTE_W-1:0] buf_addr,
  output logic [BYTE_W-1:0]   sub_out,
  output logic [3*BYTE_W-1:0] ctrl_word,
  output logic                xfer_start,
  output logic                xfer_stop,
  output logic                xfer_ack,
  output logic                soft_rst
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int NREG  = 1 << PTR_W;
  localparam logic [BYTE_W-1:0] IFS_INIT = '1;
  localparam logic [BYTE_W-1:0] HD3_INIT = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] DEC_OK   = BYTE_W'(8'h80);

  logic                   rd_fire, wr_fire, soft_hit, mask_full;
  logic [BYTE_W-1:0]      ifstat, ifctrl, ctl0, ctl1, ctl2, stat3, rd_mux;
  logic [BYTE_W-1:0]      ifstat_nx, stat3_nx;
  logic [CNT_W-1:0]       cnt, cnt_nx, wa, bp;
  logic [3:0][BYTE_W-1:0] hdr;
  logic [2:0][7:0]        bcd;

  assign wr_fire  = wr_en && !ptr_ld;
  assign rd_fire  = rd_en && !wr_en && !ptr_ld;
  assign soft_hit = wr_fire && (ptr == W_RST);

  cdc_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .ld(ptr_ld), .ld_val(ptr_val),
    .rd_step(rd_fire), .wr_step(wr_fire), .ptr(ptr)
  );

  cdc_read_track #(.NREG(NREG), .TRACK_SET(TRACK_SET)) u_trk (
    .clk(clk), .rst(rst), .clr(soft_hit), .rd_hit(rd_fire), .idx(ptr), .full(mask_full)
  );

  cdc_hdr_bcd #(.VAL_W(TIME_W), .NFIELD(3)) u_bcd (
    .vals({hdr_frm, hdr_sec, hdr_min}), .bcd(bcd)
  );

  // next state of the flags, count and decode status
  always_comb begin
    ifstat_nx = ifstat & ~flag_clr;
    cnt_nx    = cnt;
    stat3_nx  = stat3;
    if (wr_fire) begin
      case (ptr)
        W_IFCT: if (!wr_data[IFC_XEN]) begin
                  cnt_nx                = '0;
                  ifstat_nx[IFS_XFER_N] = 1'b1;
                end
        W_CNTL: cnt_nx[BYTE_W-1:0]     = wr_data;
        W_CNTH: cnt_nx[CNT_W-1:BYTE_W] = wr_data;
        W_TRIG: if (ifctrl[IFC_XEN]) ifstat_nx[IFS_XFER_N] = 1'b0;
        W_ACK:  ifstat_nx[IFS_END_N] = 1'b1;
        default: ;
      endcase
    end
    if (rd_fire && ptr == R_ST3) begin
      ifstat_nx[IFS_DEC_N] = 1'b1;
      if (ctl0[CT0_DECEN] && ifctrl[IFC_DECIE] && mask_full) stat3_nx = DEC_OK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_hit) begin
      ifstat  <= IFS_INIT;
      ifctrl  <= '0;
      cnt     <= '0;
      buf_addr <= '0;
      wa      <= WA_INIT;
      bp      <= '0;
      hdr     <= {HD3_INIT, {3*BYTE_W{1'b0}}};
      stat3   <= '0;
      ctl0    <= '0;
      ctl1    <= '0;
      ctl2    <= '0;
      sub_out <= '0;
    end else begin
      ifstat <= ifstat_nx;
      cnt    <= cnt_nx;
      stat3  <= stat3_nx;
      if (hdr_upd) hdr <= ctl1[CT1_SUBHDR] ? '0 : {HD3_INIT, bcd};
      if (wr_fire) begin
        case (ptr)
          W_SUB:  sub_out <= wr_data;
          W_IFCT: ifctrl <= wr_data;
          W_ADL:  buf_addr[BYTE_W-1:0] <= wr_data;
          W_ADH:  buf_addr[CNT_W-1:BYTE_W] <= wr_data;
          W_WAL:  wa[BYTE_W-1:0] <= wr_data;
          W_WAH:  wa[CNT_W-1:BYTE_W] <= wr_data;
          W_CT0:  ctl0 <= wr_data;
          W_CT1:  ctl1 <= wr_data;
          W_BPL:  bp[BYTE_W-1:0] <= wr_data;
          W_BPH:  bp[CNT_W-1:BYTE_W] <= wr_data;
          W_CT2:  ctl2 <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign ctrl_word = {ctl2, ctl1, ctl0};

  always_comb begin
    case (ptr)
      R_CMD:  rd_mux = '0;
      R_IFST: rd_mux = ifstat;
      R_CNTL: rd_mux = cnt[BYTE_W-1:0];
      R_CNTH: rd_mux = cnt[CNT_W-1:BYTE_W];
      R_HD0:  rd_mux = hdr[0];
      R_HD1:  rd_mux = hdr[1];
      R_HD2:  rd_mux = hdr[2];
      R_HD3:  rd_mux = hdr[3];
      R_BPL:  rd_mux = bp[BYTE_W-1:0];
      R_BPH:  rd_mux = bp[CNT_W-1:BYTE_W];
      R_WAL:  rd_mux = wa[BYTE_W-1:0];
      R_WAH:  rd_mux = wa[CNT_W-1:BYTE_W];
      R_ST0:  rd_mux = ST0_INIT;
      R_ST1:  rd_mux = '0;
      R_ST2:  rd_mux = '0;
      default: rd_mux = stat3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      xfer_start <= 1'b0;
      xfer_stop  <= 1'b0;
      xfer_ack   <= 1'b0;
      soft_rst   <= 1'b0;
    end else begin
      if (rd_fire) rd_data <= rd_mux;
      xfer_start <= wr_fire && ptr == W_TRIG && ifctrl[IFC_XEN];
      xfer_stop  <= wr_fire && ptr == W_IFCT && !wr_data[IFC_XEN];
      xfer_ack   <= wr_fire && ptr == W_ACK;
      soft_rst   <= soft_hit;
    end
  end

  // R6
  start_en_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> $past(ifctrl[IFC_XEN]));
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xfer_start, xfer_stop, xfer_ack, soft_rst}));
  // R5
  stop_state_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_stop |-> (cnt == '0 && ifstat[IFS_XFER_N]));
  // R9
  soft_rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (wa == WA_INIT && cnt == '0 && ifstat == IFS_INIT && stat3 == '0));
  // R8
  dec_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat3[7]) |-> $past(mask_full));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_fire) |-> $stable(rd_data));
endmodule

// File: tb/sim_cdc_regs.sv
module sim_cdc_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_ld = 1'b0, rd_en = 1'b0, wr_en = 1'b0, hdr_upd = 1'b0;
  logic [3:0]  ptr_val = '0;
  logic [7:0]  wr_data = '0, flag_clr = '0;
  logic [6:0]  hdr_min = '0, hdr_sec = '0, hdr_frm = '0;
  logic [7:0]  rd_data, sub_out;
  logic [3:0]  ptr;
  logic [15:0] buf_addr;
  logic [23:0] ctrl_word;
  logic        xfer_start, xfer_stop, xfer_ack, soft_rst;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cdc_regs u0 (
    .clk(clk), .rst(rst), .ptr_ld(ptr_ld), .ptr_val(ptr_val), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .flag_clr(flag_clr), .hdr_upd(hdr_upd), .hdr_min(hdr_min),
    .hdr_sec(hdr_sec), .hdr_frm(hdr_frm), .rd_data(rd_data), .ptr(ptr), .buf_addr(buf_addr),
    .sub_out(sub_out), .ctrl_word(ctrl_word), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
    .xfer_ack(xfer_ack), .soft_rst(soft_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_ptr(input logic [3:0] p);
    ptr_ld = 1'b1; ptr_val = p; tick(); ptr_ld = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] p, input logic [7:0] d);
    set_ptr(p); wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] p, output logic [7:0] v);
    set_ptr(p); rd_en = 1'b1; tick(); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic rchk(input string req, input logic [3:0] p, input logic [7:0] exp);
    logic [7:0] v;
    rreg(p, v);
    check(req, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic clr_flags(input logic [7:0] m);
    flag_clr = m; tick(); flag_clr = '0;
  endtask

  task automatic t_reset();
    check("R4 ptr", {28'h0, ptr}, 32'h0);
    check("R4 buf_addr", {16'h0, buf_addr}, 32'h0);
    rchk("R4 ifstat", 4'h1, 8'hFF);
    rchk("R4 hdr0", 4'h4, 8'h00);
    rchk("R4 hdr3", 4'h7, 8'h01);
    rchk("R4 wa low", 4'hA, 8'h60);
    rchk("R4 wa high", 4'hB, 8'h12);
    rchk("R4 status0", 4'hC, 8'h80);
    rchk("R4 count low", 4'h2, 8'h00);
    rchk("R4 status3", 4'hF, 8'h00);
  endtask

  task automatic t_read_ptr();
    set_ptr(4'h3);
    rd_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R1 read advance", {28'h0, ptr}, 32'(4 + i));
    end
    rd_en = 1'b0;
    set_ptr(4'hE);
    rd_en = 1'b1; tick();
    check("R1 read E to F", {28'h0, ptr}, 32'hF);
    tick(); rd_en = 1'b0;
    check("R1 read F holds", {28'h0, ptr}, 32'hF);
  endtask

  task automatic t_write_ptr_map();
    logic [7:0] d [4] = '{8'h34, 8'h12, 8'hCD, 8'hAB};
    set_ptr(4'h2);
    wr_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wr_data = d[i]; tick();
    end
    wr_en = 1'b0;
    check("R2 write advance", {28'h0, ptr}, 32'h6);
    check("R3 buffer address", {16'h0, buf_addr}, 32'hABCD);
    wr_en = 1'b1; wr_data = 8'h00; tick(); wr_en = 1'b0;
    check("R2 write 6 holds", {28'h0, ptr}, 32'h6);
    check("R6 trigger disabled no pulse", {31'h0, xfer_start}, 32'h0);
    wreg(4'h7, 8'h00);
    check("R2 write 7 holds", {28'h0, ptr}, 32'h7);
    wreg(4'hE, 8'h5A);
    check("R2 write E holds", {28'h0, ptr}, 32'hE);
    check("R3 control 2", {8'h0, ctrl_word}, 32'h5A0000);
    wreg(4'h0, 8'h77);
    check("R2 write 0 advance", {28'h0, ptr}, 32'h1);
    check("R3 sub out", {24'h0, sub_out}, 32'h77);
    rchk("R3 count low", 4'h2, 8'h34);
    rchk("R3 count high", 4'h3, 8'h12);
    wreg(4'h8, 8'h11); wreg(4'h9, 8'h22);
    rchk("R3 wa low", 4'hA, 8'h11);
    rchk("R3 wa high", 4'hB, 8'h22);
    wreg(4'hC, 8'h33); wreg(4'hD, 8'h44);
    rchk("R3 bp low", 4'h8, 8'h33);
    rchk("R3 bp high", 4'h9, 8'h44);
  endtask

  task automatic t_stop_trigger_ack();
    wreg(4'h1, 8'h00);
    check("R5 stop pulse", {31'h0, xfer_stop}, 32'h1);
    tick();
    check("R11 stop pulse width", {31'h0, xfer_stop}, 32'h0);
    rchk("R5 count cleared", 4'h2, 8'h00);
    rchk("R5 count high cleared", 4'h3, 8'h00);
    wreg(4'h6, 8'h00);
    check("R6 no start when disabled", {31'h0, xfer_start}, 32'h0);
    rchk("R6 ifstat unchanged", 4'h1, 8'hFF);
    wreg(4'h1, 8'h02);
    check("R5 no stop with enable", {31'h0, xfer_stop}, 32'h0);
    wreg(4'h6, 8'h00);
    check("R6 start pulse", {31'h0, xfer_start}, 32'h1);
    tick();
    check("R11 start pulse width", {31'h0, xfer_start}, 32'h0);
    rchk("R6 ifstat bit3 cleared", 4'h1, 8'hF7);
    clr_flags(8'h40);
    rchk("R7 flag cleared by datapath", 4'h1, 8'hB7);
    wreg(4'h7, 8'h00);
    check("R7 ack pulse", {31'h0, xfer_ack}, 32'h1);
    tick();
    check("R11 ack pulse width", {31'h0, xfer_ack}, 32'h0);
    rchk("R7 ifstat bit6 set", 4'h1, 8'hF7);
    clr_flags(8'h20);
    rchk("R8 bit5 cleared by datapath", 4'h1, 8'hD7);
    rchk("R8 status3 read", 4'hF, 8'h00);
    rchk("R8 bit5 set by status3 read", 4'h1, 8'hF7);
  endtask

  task automatic t_soft_reset();
    wreg(4'hF, 8'h00);
    check("R9 soft reset pulse", {31'h0, soft_rst}, 32'h1);
    check("R9 pointer stays F", {28'h0, ptr}, 32'hF);
    check("R9 buf_addr cleared", {16'h0, buf_addr}, 32'h0);
    tick();
    check("R11 soft reset width", {31'h0, soft_rst}, 32'h0);
    rchk("R9 ifstat restored", 4'h1, 8'hFF);
    rchk("R9 wa restored", 4'hA, 8'h60);
    rchk("R9 hdr3 restored", 4'h7, 8'h01);
  endtask

  task automatic read_tracked(input bit skip_e);
    logic [7:0] v;
    logic [3:0] lst [10] = '{4'h1, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE};
    for (int i = 0; i < 10; i++)
      if (!(skip_e && lst[i] == 4'hE)) rreg(lst[i], v);
  endtask

  task automatic t_decode_ready();
    wreg(4'hF, 8'h00);
    wreg(4'hA, 8'h80);
    wreg(4'h1, 8'h22);
    read_tracked(1'b1);
    rchk("R8 partial mask", 4'hF, 8'h00);
    rchk("R8 partial mask stays", 4'hF, 8'h00);
    rchk("R8 last tracked", 4'hE, 8'h00);
    rchk("R8 first status3 read old", 4'hF, 8'h00);
    rchk("R8 decode ready", 4'hF, 8'h80);
    wreg(4'hF, 8'h00);
    rchk("R9 status3 cleared", 4'hF, 8'h00);
    wreg(4'hA, 8'h80);
    wreg(4'h1, 8'h02);
    read_tracked(1'b0);
    rchk("R8 irq enable clear", 4'hF, 8'h00);
    rchk("R8 irq enable clear stays", 4'hF, 8'h00);
    wreg(4'hF, 8'h00);
    wreg(4'h1, 8'h22);
    read_tracked(1'b0);
    wreg(4'hF, 8'h00);
    wreg(4'hA, 8'h80);
    wreg(4'h1, 8'h22);
    rchk("R9 tracking cleared", 4'hF, 8'h00);
    rchk("R9 tracking cleared stays", 4'hF, 8'h00);
  endtask

  task automatic hdr_load(input int m, input int s, input int f);
    hdr_min = 7'(m); hdr_sec = 7'(s); hdr_frm = 7'(f);
    hdr_upd = 1'b1; tick(); hdr_upd = 1'b0;
  endtask

  task automatic t_header();
    wreg(4'hF, 8'h00);
    hdr_load(12, 34, 56);
    rchk("R10 minute", 4'h4, 8'h12);
    rchk("R10 second", 4'h5, 8'h34);
    rchk("R10 frame", 4'h6, 8'h56);
    rchk("R10 mode byte", 4'h7, 8'h01);
    hdr_load(59, 9, 74);
    rchk("R10 minute 59", 4'h4, 8'h59);
    rchk("R10 second 09", 4'h5, 8'h09);
    rchk("R10 frame 74", 4'h6, 8'h74);
    wreg(4'hB, 8'h01);
    hdr_load(1, 2, 3);
    rchk("R10 sub-header zero", 4'h4, 8'h00);
    rchk("R10 sub-header byte3 zero", 4'h7, 8'h00);
  endtask

  task automatic t_rd_hold();
    logic [7:0] v;
    rreg(4'hC, v);
    for (int i = 0; i < 3; i++) tick();
    check("R12 hold idle", {24'h0, rd_data}, 32'h80);
    wreg(4'h0, 8'h99);
    check("R12 hold over write", {24'h0, rd_data}, 32'h80);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_read_ptr();
    t_write_ptr_map();
    t_stop_trigger_ack();
    t_soft_reset();
    t_decode_ready();
    t_header();
    t_rd_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule